// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block steps one analog-to-digital converter through a bank of analog inputs that share it through an external multiplexer. Each time a conversion-rate tick is accepted, the block moves its channel counter on by one. The counter drives the multiplexer select lines directly. The block then holds back the convert command for a settling window, so the multiplexer and its buffer can reach the new input before the converter samples it.

When the window expires, the block sends a single-cycle convert strobe. At that moment it captures the channel number into a tag register. The tag stays valid for the whole serial result, so it can be joined to that result even if the select lines move on in the meantime. The settling window is given in nanoseconds together with the clock frequency, and the block turns it into a whole number of clock cycles.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `mux_sel` is 0 and `settle_busy`, `conv_start` and `chan_tag` are all 0.
- R2: A tick that is accepted (`rate_tick` high while `settle_busy` is low) moves `mux_sel` on by one at the next clock edge. The select is a 3-bit binary channel number with the default of 8 channels, and it wraps from 7 to 0.
- R3: `settle_busy` goes high in the cycle after an accepted tick and stays high for exactly SETTLE_CYC cycles. SETTLE_CYC is the smallest number of clock cycles whose total duration at CLK_HZ is at least SETTLE_NS. It is never less than 1.
- R4: `conv_start` is high for exactly one cycle, in the cycle right after `settle_busy` falls. It is never high at any other time.
- R5: A tick that arrives while `settle_busy` is high has no effect. `mux_sel` stays the same and the settling window is not restarted.
- R6: `chan_tag` takes the value of `mux_sel` in the cycle `conv_start` is high. It keeps that value until the next `conv_start`, even when `mux_sel` changes.
- R7: A tick in the cycle `conv_start` is high is accepted, because `settle_busy` is low in that cycle. It starts the next channel straight away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_tick | input | 1 | Conversion-rate request, one cycle per request |
| mux_sel | output | ADDR_W | Multiplexer channel select |
| conv_start | output | 1 | One-cycle convert command to the ADC |
| chan_tag | output | ADDR_W | Channel number of the conversion in progress |
| settle_busy | output | 1 | High while the settling window is running |

## Verification
Some rules are checked by assertions on every cycle. These are: the strobe is one cycle long, it follows only the falling edge of the busy flag, and the busy flag lasts exactly the computed window. They also check that the select moves only on an accepted tick, moving up by one with wrap, and that the tag changes only together with a strobe. Other behaviour can only be shown by the bench's scenarios. These are the sweep through several full wraps of the channel order, which proves the ignored ticks really had no effect. They are also the back-to-back ticks placed on the strobe cycle, where the tag must still show the old channel while the select already names the next one.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  // Smallest whole cycle count covering a time span, never below one.
  function automatic int settle_cycles(input longint clk_hz, input longint span_ns);
    longint num;
    longint cyc;
    num = clk_hz * span_ns;
    cyc = (num + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc < 1) cyc = 1;
    return int'(cyc);
  endfunction

  // Channel that follows a given one in the scan order.
  function automatic int next_chan(input int cur, input int num_ch);
    return (cur >= num_ch - 1) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/scan_addr_ctr.sv
module scan_addr_ctr #(
  parameter int NUM_CH = 8,
  localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  import adc_scan_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (step) begin
      addr <= ADDR_W'(next_chan(int'(addr), NUM_CH));
    end
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_CYC = 300,
  localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic expire,
  output logic pulse
);
  logic [CNT_W-1:0] remain;

  assign expire = busy && (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
      pulse  <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (busy) begin
        if (expire) begin
          busy  <= 1'b0;
          pulse <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
        end
      end else if (start) begin
        busy   <= 1'b1;
        remain <= CNT_W'(SETTLE_CYC - 1);
      end
    end
  end
endmodule

// File: rtl/tag_hold.sv
module tag_hold #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int SETTLE_NS = 3000,
  parameter int NUM_CH    = 8,
  localparam int ADDR_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SETTLE_CYC = adc_scan_pkg::settle_cycles(longint'(CLK_HZ), longint'(SETTLE_NS))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rate_tick,
  output logic [ADDR_W-1:0] mux_sel,
  output logic              conv_start,
  output logic [ADDR_W-1:0] chan_tag,
  output logic              settle_busy
);
  // Named internal events, also observed by the checker.
  logic tick_accept;
  logic settle_expire;

  assign tick_accept = rate_tick && !settle_busy;

  scan_addr_ctr #(.NUM_CH(NUM_CH)) u_addr (
    .clk  (clk),
    .rst  (rst),
    .step (tick_accept),
    .addr (mux_sel)
  );

  settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (tick_accept),
    .busy   (settle_busy),
    .expire (settle_expire),
    .pulse  (conv_start)
  );

  // Capture at the same edge that raises the strobe; the select is stable then.
  tag_hold #(.W(ADDR_W)) u_tag (
    .clk  (clk),
    .rst  (rst),
    .load (settle_expire),
    .d    (mux_sel),
    .q    (chan_tag)
  );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int SETTLE_CYC = 300,
  parameter int NUM_CH     = 8,
  parameter int ADDR_W     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              rate_tick,
  input logic [ADDR_W-1:0] mux_sel,
  input logic              conv_start,
  input logic [ADDR_W-1:0] chan_tag,
  input logic              settle_busy,
  input logic              tick_accept,
  input logic              settle_expire
);
  int busy_len;

  always_ff @(posedge clk) begin
    if (rst) busy_len <= 0;
    else if (settle_busy) busy_len <= busy_len + 1;
    else busy_len <= 0;
  end

  assert_wrap_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(mux_sel) |-> (int'(mux_sel) == ((int'($past(mux_sel)) == NUM_CH - 1) ? 0 : int'($past(mux_sel)) + 1)));

  assert_sel_on_accept_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(mux_sel) |-> $past(rate_tick && !settle_busy));

  assert_busy_bound_R3: assert property (@(posedge clk) disable iff (rst)
    settle_busy |-> (busy_len < SETTLE_CYC));

  assert_busy_full_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(settle_busy) |-> (busy_len == SETTLE_CYC));

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  assert_pulse_after_fall_R4: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> ($past(settle_busy) && !settle_busy));

  assert_fall_gives_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(settle_busy) |-> conv_start);

  assert_busy_tick_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (rate_tick && settle_busy) |=> $stable(mux_sel));

  assert_tag_moves_with_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_tag) |-> conv_start);

  assert_tag_matches_sel_R6: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> (chan_tag == mux_sel));

  assert_expire_internal_R4: assert property (@(posedge clk) disable iff (rst)
    settle_expire |=> conv_start);

  assert_accept_starts_R7: assert property (@(posedge clk) disable iff (rst)
    tick_accept |=> settle_busy);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(
  .SETTLE_CYC (SETTLE_CYC),
  .NUM_CH     (NUM_CH),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .rate_tick     (rate_tick),
  .mux_sel       (mux_sel),
  .conv_start    (conv_start),
  .chan_tag      (chan_tag),
  .settle_busy   (settle_busy),
  .tick_accept   (tick_accept),
  .settle_expire (settle_expire)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T_HZ  = 5_000_000;
  localparam int T_NS  = 3000;
  localparam int T_CH  = 8;
  localparam int T_AW  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rate_tick = 1'b0;
  logic [T_AW-1:0] mux_sel;
  logic conv_start;
  logic [T_AW-1:0] chan_tag;
  logic settle_busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_seq #(.CLK_HZ(T_HZ), .SETTLE_NS(T_NS), .NUM_CH(T_CH)) u_adc_scan_seq (
    .clk         (clk),
    .rst         (rst),
    .rate_tick   (rate_tick),
    .mux_sel     (mux_sel),
    .conv_start  (conv_start),
    .chan_tag    (chan_tag),
    .settle_busy (settle_busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected window length: count cycles until their total time reaches the span.
  function automatic int want_cycles();
    longint n = 1;
    while (n * 64'd1_000_000_000 < longint'(T_NS) * longint'(T_HZ)) n++;
    return int'(n);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int exp_sel;
    int exp_tag;
    int s_cyc;
    bit pending;
    s_cyc = want_cycles();
    exp_sel = 0;
    exp_tag = 0;
    pending = 1'b0;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(mux_sel == 0, "R1 sel", int'(mux_sel), 0);
    check(!settle_busy, "R1 busy", int'(settle_busy), 0);
    check(!conv_start, "R1 conv", int'(conv_start), 0);
    check(chan_tag == 0, "R1 tag", int'(chan_tag), 0);

    // Idle with no tick: nothing moves.
    repeat (5) @(negedge clk);
    check(mux_sel == 0 && !settle_busy, "R1 idle", int'(mux_sel), 0);

    for (int it = 0; it < 20; it++) begin
      int cnt;
      if (!pending) begin
        rate_tick = 1'b1;
        @(negedge clk);
      end
      rate_tick = 1'b0;
      exp_sel = (exp_sel == T_CH - 1) ? 0 : exp_sel + 1;
      check(int'(mux_sel) == exp_sel, "R2 advance", int'(mux_sel), exp_sel);
      check(settle_busy, "R3 busy start", int'(settle_busy), 1);
      if (pending) begin
        check(!conv_start, "R4 after chain", int'(conv_start), 0);
        check(int'(chan_tag) == exp_tag, "R6 tag held over next select", int'(chan_tag), exp_tag);
        check(settle_busy, "R7 chained tick accepted", int'(settle_busy), 1);
      end
      cnt = 1;
      forever begin
        rate_tick = (cnt == 2) || (it % 3 == 0 && cnt == s_cyc - 1);
        @(negedge clk);
        if (!settle_busy) break;
        cnt++;
        if (cnt > s_cyc + 4) break;
      end
      rate_tick = 1'b0;
      check(cnt == s_cyc, "R3 window length", cnt, s_cyc);
      check(int'(mux_sel) == exp_sel, "R5 busy tick ignored", int'(mux_sel), exp_sel);
      check(conv_start, "R4 strobe after busy", int'(conv_start), 1);
      exp_tag = exp_sel;
      check(int'(chan_tag) == exp_tag, "R6 tag capture", int'(chan_tag), exp_tag);
      if (it % 2 == 1) begin
        rate_tick = 1'b1;
        pending = 1'b1;
        @(negedge clk);
      end else begin
        pending = 1'b0;
        @(negedge clk);
        check(!conv_start, "R4 strobe one cycle", int'(conv_start), 0);
        check(!settle_busy, "R5 window not restarted", int'(settle_busy), 0);
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule